// File: doc/BRIEF.md
# Interlocked panel instruction encoder

This block turns the button state of a front-panel instruction entry unit into a 16-bit instruction word. The operator picks an opcode from two rows of push-buttons. The control row holds nine opcodes and an escape key that hands the upper opcode bits to the arithmetic row. A format bank chooses a 4-bit immediate, an 8-bit immediate or register mode. Two banks of eight keys pick the destination and source register numbers.

Each bank keeps its choice in a one-hot register, the way mechanically interlocked keys stay down. The arithmetic row is not interlocked with the control row, so its choice is kept while the control row changes.

The encoder adds hex-digit immediate inputs, a condition nibble and an extension flag, according to the opcode and the format. It drives the word together with four field-enable outputs. Fields are positive logic, so a field that is not enabled reads as zero.

Top module: `panel_insn_encoder`

## Requirements
- R1: After reset no opcode key is held, escape is off, the 4-bit-immediate format is active and both register banks hold key 0. Two clock edges after reset is released, `insn` is 0x8000 with the `imm_lo` value in bits 3:0, and only `imm_lo_en` is high.
- R2: A press in a bank latches the lowest-numbered pressed key of that bank on the next clock edge and releases the other keys of that bank. A bank with no key pressed keeps its choice.
- R3: The control row (`ctl_btn`: 0 SH, 1 SA, 2 RO, 3 RC, 4 LDCL, 5 LDCH, 6 IN, 7 OUT, 8 INV, 9 escape) and the arithmetic row (`alu_btn`: 0 AND, 1 OR, 2 XOR, 3 ANDN, 4 CMPU, 5 CMPS, 6 SUB, 7 ADD, 8 SET, 9 CALL) latch independently. The arithmetic choice affects the word only while escape is the latched control key.
- R4: Bit 15 is 1 while escape is off. While escape is on, bit 15 is 1 only for SET or CALL.
- R5: Bits 15:12 are, with escape off: SH 1010, SA 1010, RO 1011, RC 1011, LDCL 1100, LDCH 1100, IN 1101, OUT 1110, INV 1111, and 1000 with no key held. With escape on they are the arithmetic key index in binary, and 0000 with no arithmetic key held.
- R6: Bit 11 is 1 when escape is on with the 8-bit format held, or when SA, RC or LDCH is held, or when IN or OUT is held while `wide_io` is 1.
- R7: Format keys are 0 (4-bit immediate), 1 (8-bit immediate) and 2 (register). The 8-bit format applies only while escape is on. Otherwise it acts as the 4-bit format.
- R8: `imm_hi_en` is high for IN, for OUT, or for escape together with the 8-bit format. `imm_lo_en` is high in those cases and also in the effective 4-bit format. Bits 7:4 carry `imm_hi` and bits 3:0 carry `imm_lo` when the enables are high.
- R9: `src_en` is high only in register format with none of IN, OUT or INV held. It places {`ext_flag`, source register number} in bits 7:4.
- R10: `cond_en` is high in register format when `imm_lo_en` is low, and it places `cond_in` in bits 3:0.
- R11: Bits 10:8 always carry the destination register number, which is the index of the latched destination key.
- R12: Any nibble whose enables are all low is 0. `imm_hi_en` and `src_en` are never both high, and neither are `imm_lo_en` and `cond_en`.
- R13: The outputs are registered: a press latched at one edge shows up at the outputs after the following edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_btn | input | 10 | Control-row keys, index 9 is escape |
| alu_btn | input | 10 | Arithmetic-row keys |
| fmt_btn | input | 3 | Format keys: 4-bit imm, 8-bit imm, register |
| dst_btn | input | 8 | Destination register keys |
| src_btn | input | 8 | Source register keys |
| imm_hi | input | 4 | Upper immediate hex digit |
| imm_lo | input | 4 | Lower immediate hex digit |
| cond_in | input | 4 | Condition nibble for register format |
| ext_flag | input | 1 | Extension flag placed at bit 7 with the source field |
| wide_io | input | 1 | 9-bit immediate flag for IN/OUT |
| insn | output | 16 | Encoded instruction word |
| imm_hi_en | output | 1 | Upper immediate nibble enabled |
| imm_lo_en | output | 1 | Lower immediate nibble enabled |
| src_en | output | 1 | Source register field enabled |
| cond_en | output | 1 | Condition nibble enabled |

## Verification
The bench runs every control opcode under each format with both `wide_io` values, and every arithmetic opcode under each format with escape on. A row multiplexer without escape gating would leak arithmetic bits into control words. A wrong fallback of the 8-bit format would turn on the upper nibble or bit 11 outside escape mode. The bench also presses several keys in one cycle, where picking the wrong priority latches another opcode or register. It switches the control row after an arithmetic pick, which shows up any design that interlocks the two rows. It checks register format with IN, OUT and INV, where missing gating lets the source field or the condition nibble collide with immediates. A single cycle-exact probe catches outputs that arrive one edge early or late.

// File: rtl/panel_insn_encoder.sv
module panel_insn_encoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  ctl_btn,
  input  logic [9:0]  alu_btn,
  input  logic [2:0]  fmt_btn,
  input  logic [7:0]  dst_btn,
  input  logic [7:0]  src_btn,
  input  logic [3:0]  imm_hi,
  input  logic [3:0]  imm_lo,
  input  logic [3:0]  cond_in,
  input  logic        ext_flag,
  input  logic        wide_io,
  output logic [15:0] insn,
  output logic        imm_hi_en,
  output logic        imm_lo_en,
  output logic        src_en,
  output logic        cond_en
);
  localparam int K_SH = 0, K_SA = 1, K_RO = 2, K_RC = 3, K_LDL = 4, K_LDH = 5;
  localparam int K_IN = 6, K_OUT = 7, K_INV = 8, K_ESC = 9;
  localparam int A_OR = 1, A_XOR = 2, A_ANDN = 3, A_CMPU = 4, A_CMPS = 5;
  localparam int A_SUB = 6, A_ADD = 7, A_SET = 8, A_CALL = 9;
  localparam int F_I4 = 0, F_I8 = 1, F_REG = 2;

  function automatic logic [2:0] enc8(input logic [7:0] oh);
    enc8 = '0;
    for (int i = 0; i < 8; i++)
      if (oh[i]) enc8 |= 3'(i);
  endfunction

  logic [9:0] ctl_q, alu_q;
  logic [2:0] fmt_q;
  logic [7:0] dst_q, src_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0;
      alu_q <= '0;
      fmt_q <= 3'b001;
      dst_q <= 8'b1;
      src_q <= 8'b1;
    end else begin
      if (|ctl_btn) ctl_q <= ctl_btn & (~ctl_btn + 10'd1);
      if (|alu_btn) alu_q <= alu_btn & (~alu_btn + 10'd1);
      if (|fmt_btn) fmt_q <= fmt_btn & (~fmt_btn + 3'd1);
      if (|dst_btn) dst_q <= dst_btn & (~dst_btn + 8'd1);
      if (|src_btn) src_q <= src_btn & (~src_btn + 8'd1);
    end

  wire esc  = ctl_q[K_ESC];
  wire io   = ctl_q[K_IN] | ctl_q[K_OUT];
  wire i8   = esc & fmt_q[F_I8];
  wire i4   = fmt_q[F_I4] | (fmt_q[F_I8] & ~esc);
  wire regm = fmt_q[F_REG];

  wire [3:0] top_alu = {
    alu_q[A_SET] | alu_q[A_CALL],
    alu_q[A_CMPU] | alu_q[A_CMPS] | alu_q[A_SUB] | alu_q[A_ADD],
    alu_q[A_XOR] | alu_q[A_ANDN] | alu_q[A_SUB] | alu_q[A_ADD],
    alu_q[A_OR] | alu_q[A_ANDN] | alu_q[A_CMPS] | alu_q[A_ADD] | alu_q[A_CALL]};

  wire [3:0] top_ctl = {
    1'b1,
    ctl_q[K_LDL] | ctl_q[K_LDH] | io | ctl_q[K_INV],
    ctl_q[K_SH] | ctl_q[K_SA] | ctl_q[K_RO] | ctl_q[K_RC] | ctl_q[K_OUT] | ctl_q[K_INV],
    ctl_q[K_RO] | ctl_q[K_RC] | ctl_q[K_IN] | ctl_q[K_INV]};

  wire b11  = i8 | ctl_q[K_SA] | ctl_q[K_RC] | ctl_q[K_LDH] | (wide_io & io);
  wire hi_n = io | i8;
  wire lo_n = hi_n | i4;
  wire sr_n = regm & ~io & ~ctl_q[K_INV];
  wire cd_n = regm & ~lo_n;

  wire [3:0] nib_hi = ({4{hi_n}} & imm_hi) | ({4{sr_n}} & {ext_flag, enc8(src_q)});
  wire [3:0] nib_lo = ({4{lo_n}} & imm_lo) | ({4{cd_n}} & cond_in);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      insn      <= '0;
      imm_hi_en <= 1'b0;
      imm_lo_en <= 1'b0;
      src_en    <= 1'b0;
      cond_en   <= 1'b0;
    end else begin
      insn      <= {esc ? top_alu : top_ctl, b11, enc8(dst_q), nib_hi, nib_lo};
      imm_hi_en <= hi_n;
      imm_lo_en <= lo_n;
      src_en    <= sr_n;
      cond_en   <= cd_n;
    end
endmodule

module panel_insn_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  ctl_btn,
  input logic [9:0]  ctl_q,
  input logic [9:0]  alu_q,
  input logic [2:0]  fmt_q,
  input logic [15:0] insn,
  input logic        imm_hi_en,
  input logic        imm_lo_en,
  input logic        src_en,
  input logic        cond_en
);
  // R2
  ctl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_btn) |=> $onehot(ctl_q));
  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ctl_btn) |=> $stable(ctl_q));
  // R3
  alu_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alu_q) && $onehot0(fmt_q));
  // R4
  b15_noesc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[9] |=> insn[15]);
  // R7
  fmt_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[9] && fmt_q[1]) |=> imm_lo_en);
  // R9
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[6] || ctl_q[7] || ctl_q[8]) |=> !src_en);
  // R12
  hi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_hi_en && src_en));
  // R12
  lo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_lo_en && cond_en));
endmodule

bind panel_insn_encoder panel_insn_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_btn(ctl_btn), .ctl_q(ctl_q), .alu_q(alu_q),
  .fmt_q(fmt_q), .insn(insn), .imm_hi_en(imm_hi_en), .imm_lo_en(imm_lo_en),
  .src_en(src_en), .cond_en(cond_en));

// File: tb/panel_insn_encoder_test.sv
`timescale 1ns/1ps
module panel_insn_encoder_test;
  logic clk = 0, rst_n = 0;
  logic [9:0] ctl_btn = 0, alu_btn = 0;
  logic [2:0] fmt_btn = 0;
  logic [7:0] dst_btn = 0, src_btn = 0;
  logic [3:0] imm_hi = 4'h5, imm_lo = 4'h9, cond_in = 4'h6;
  logic ext_flag = 1, wide_io = 0;
  logic [15:0] insn;
  logic imm_hi_en, imm_lo_en, src_en, cond_en;

  int total = 0, bad = 0;
  always #2 clk = ~clk;

  panel_insn_encoder uut (.*);

  typedef struct { logic [19:0] v; string tag; } item_t;
  item_t q[$];
  event chk_ev;

  int ma = -1, mb = -1, mf = 0, md = 0, ms = 0;
  logic [3:0] ctl_top [9] = '{4'ha, 4'ha, 4'hb, 4'hb, 4'hc, 4'hc, 4'hd, 4'he, 4'hf};

  function automatic int first_set(input logic [9:0] v, input int cur);
    for (int i = 0; i < 10; i++) if (v[i]) return i;
    return cur;
  endfunction

  function automatic logic [19:0] expect_out();
    logic esc, io, inv, hen, len, sen, cen, b11;
    logic [3:0] top, hn, ln;
    esc = (ma == 9); io = (ma == 6 || ma == 7); inv = (ma == 8);
    if (esc) top = (mb >= 0) ? 4'(mb) : 4'h0;
    else top = (ma >= 0) ? ctl_top[ma] : 4'h8;
    b11 = (esc && mf == 1) || ma == 1 || ma == 3 || ma == 5 || (wide_io && io);
    hen = io || (esc && mf == 1);
    len = hen || mf == 0 || (mf == 1 && !esc);
    sen = (mf == 2) && !io && !inv;
    cen = (mf == 2) && !len;
    hn = hen ? imm_hi : sen ? {ext_flag, 3'(ms)} : 4'h0;
    ln = len ? imm_lo : cen ? cond_in : 4'h0;
    return {top, b11, 3'(md), hn, ln, hen, len, sen, cen};
  endfunction

  task automatic press(input logic [9:0] c, input logic [9:0] a, input logic [2:0] f,
                       input logic [7:0] d, input logic [7:0] s, input string tag);
    item_t it;
    @(negedge clk);
    ctl_btn = c; alu_btn = a; fmt_btn = f; dst_btn = d; src_btn = s;
    ma = first_set(c, ma); mb = first_set(a, mb);
    mf = first_set({7'b0, f}, mf); md = first_set({2'b0, d}, md); ms = first_set({2'b0, s}, ms);
    @(negedge clk);
    ctl_btn = 0; alu_btn = 0; fmt_btn = 0; dst_btn = 0; src_btn = 0;
    @(negedge clk);
    it.v = expect_out(); it.tag = tag;
    q.push_back(it);
    -> chk_ev;
  endtask

  initial forever begin
    item_t it;
    logic [19:0] got;
    @(chk_ev);
    while (q.size() > 0) begin
      it = q.pop_front();
      got = {insn, imm_hi_en, imm_lo_en, src_en, cond_en};
      total++;
      if (got !== it.v) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.v);
      end
    end
  end

  initial begin
    #(4ns * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    item_t it;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    it.v = expect_out(); it.tag = "R1 reset"; q.push_back(it); -> chk_ev;

    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 9; i++)
        for (int w = 0; w < 2; w++) begin
          wide_io = w[0]; imm_hi = 4'(i + 3); imm_lo = 4'(15 - i); cond_in = 4'(i ^ 5);
          ext_flag = i[0];
          press(10'(1 << i), 0, 3'(1 << f), 8'(1 << ((i + f) % 8)), 8'(1 << (i % 8)),
                "R5/R6/R7/R8/R9/R10/R12 ctl row");
        end

    for (int f = 0; f < 3; f++)
      for (int j = 0; j < 10; j++) begin
        wide_io = j[1];
        press(10'(1 << 9), 10'(1 << j), 3'(1 << f), 0, 8'(1 << (7 - j % 8)),
              "R3/R4/R5/R6/R7/R8/R10 alu row");
      end

    press(10'b0011000100, 10'b1010000000, 3'b110, 8'b10100000, 8'b01001000, "R2 lowest wins");
    press(0, 0, 0, 0, 0, "R2 hold");
    press(10'(1 << 9), 10'(1 << 7), 3'b100, 0, 0, "R3 esc add");
    press(10'(1 << 0), 0, 0, 0, 0, "R3 ctl over alu");
    press(10'(1 << 9), 0, 0, 0, 0, "R3 alu kept");
    press(10'(1 << 8), 10'(1 << 9), 0, 0, 0, "R3 alu hidden");
    press(10'(1 << 9), 0, 3'b010, 0, 0, "R4 call esc");
    for (int d = 0; d < 8; d++)
      press(0, 0, 0, 8'(1 << d), 0, "R11 dst field");

    // R13 latency probe
    @(negedge clk);
    prev = insn;
    ctl_btn = 10'(1 << 8); ma = 8;
    @(negedge clk);
    ctl_btn = 0;
    total++;
    if (insn !== prev) begin
      bad++;
      $display("FAIL R13 early: got %h expected %h", insn, prev);
    end
    @(negedge clk);
    it.v = expect_out(); it.tag = "R13 arrival"; q.push_back(it); -> chk_ev;

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule